// File: doc/BRIEF.md
# Speculative Read Beat Qualifier

This unit sits on the master side of a split-transaction data bus. Once a data tenure has been opened, it counts the data beats as the slave acknowledges them. A tenure is either a single beat or a four-beat burst, and either a read or a write. Each read beat is captured on the cycle its acknowledge is high. The beat is held as speculative. It is released to the core one cycle later, but only if the slave does not raise the late data-retry line in the cycle right after that acknowledge. A retried beat is thrown away, and its slot in the burst is filled by the next acknowledge that arrives after retry has dropped.

The unit also owns the data-bus-busy indication. Busy stays high for as long as retry is high, after both reads and writes, so that no other tenure can start. A bus-error input ends the tenure early and drops any speculative beat. It reports the error to the core. Retry raised when there was no acknowledge in the cycle before is flagged as a protocol violation.

A tenure is opened by a start pulse while the bus is idle. The core sees a one-cycle commit pulse for each confirmed read beat, carrying the beat index and the 64-bit data.

Top module: `beat_qualifier`

## Requirements
- R1: After a synchronous active-low reset, busy_o, commit_o, err_o and proto_err_o are all low.
- R2: A start_i pulse while busy_o is low makes busy_o high on the next cycle. start_rd_i=1 selects a read, and start_burst_i=1 selects four beats instead of one. A start_i pulse while busy_o is high is ignored.
- R3: A read beat sampled with ta_i in cycle t, followed by retry_i low in cycle t+1, produces commit_o high in cycle t+2. That pulse carries the data from cycle t and the beat's index.
- R4: A read beat whose next cycle has retry_i high never commits. Acknowledges that arrive while retry_i is high are ignored. The next acknowledge after retry drops brings the replacement data, with the same index as the cancelled beat.
- R5: Cycles with ta_i low move no beat forward and produce no commit. The burst resumes when ta_i returns.
- R6: A read burst commits exactly four beats with indices 0,1,2,3 in that order. A single read commits one beat with index 0. busy_o falls two cycles after the last acknowledge when no retry follows it.
- R7: During a write, retry_i has no effect on beat counting and never causes a commit. A retry after the final write beat still holds busy_o high.
- R8: busy_o stays high in every cycle that follows a cycle in which both busy_o and retry_i were high. It falls one cycle after the first cycle with retry_i low that ends the tenure.
- R9: retry_i rising when ta_i was low in the previous cycle makes proto_err_o pulse high in the next cycle.
- R10: tea_i while busy_o is high discards any speculative beat and pulses err_o in the next cycle. busy_o then falls in the next cycle, or, if retry_i is high, one cycle after retry_i drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Open a data tenure (accepted only when idle) |
| start_rd_i | input | 1 | Tenure is a read (1) or a write (0) |
| start_burst_i | input | 1 | Tenure is a four-beat burst (1) or a single beat (0) |
| ta_i | input | 1 | Transfer acknowledge for the current beat |
| retry_i | input | 1 | Late data retry for the beat acknowledged one cycle earlier |
| tea_i | input | 1 | Bus error, ends the tenure |
| data_i | input | 64 | Read data presented with ta_i |
| busy_o | output | 1 | Data bus busy |
| commit_o | output | 1 | One-cycle pulse: a confirmed read beat for the core |
| commit_idx_o | output | 2 | Beat index of the committed beat |
| commit_data_o | output | 64 | Data of the committed beat |
| err_o | output | 1 | One-cycle pulse: tenure ended by bus error |
| proto_err_o | output | 1 | One-cycle pulse: retry without a preceding acknowledge |

## Verification
The bench goes after a retry on a middle burst beat while acknowledge stays high. A design that did not roll its beat count back would skip an index, or commit the cancelled data. Retry lasting several cycles after the final write beat shows whether busy is dropped too early, which would let a new tenure start during retry. A bus error while a beat is still speculative checks that the beat is dropped rather than committed. Acknowledge gaps inside a burst catch a pipeline that moves forward without an acknowledge. Random tenures mix all of these, together with retries that have no acknowledge before them.

// File: rtl/bq_pkg.sv
// Shared types for the speculative read beat qualifier.
package bq_pkg;
    // Tenure state: idle, beats in flight, or waiting for retry to end
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } bq_state_e;
endpackage

// File: rtl/bq_ctrl.sv
// Tenure control for the beat qualifier.
// What it does: tracks the tenure state and the beat count, and keeps the
// valid flag and index of the one speculative read beat.
// Assumes: retry is meaningful only in the cycle after an acknowledge,
// and bus error wins over acknowledge and retry in the same cycle.
module bq_ctrl
    import bq_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             start_rd_i,
    input  logic             start_burst_i,
    input  logic             ta_i,
    input  logic             retry_i,
    input  logic             tea_i,
    output logic             busy_o,
    output logic             take_o,
    output logic             confirm_o,
    output logic [IDX_W-1:0] confirm_idx_o,
    output logic             abort_o
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    bq_state_e          state_q;
    logic               rd_q;
    logic               burst_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               pv_q;
    logic [IDX_W-1:0]   pidx_q;
    logic [CNT_W-1:0]   last_cnt;
    logic               more;
    logic               in_x;
    logic               rd_ok;
    logic               wr_beat;
    logic               last_commit;

    // Decode beat qualification for the current cycle
    always_comb begin
        last_cnt      = burst_q ? CNT_W'(BURST_LEN) : CNT_W'(1);
        more          = cnt_q < last_cnt;
        in_x          = state_q == ST_XFER;
        rd_ok         = in_x && rd_q && !retry_i && !tea_i;
        take_o        = rd_ok && ta_i && more;
        confirm_o     = rd_ok && pv_q;
        confirm_idx_o = pidx_q;
        wr_beat       = in_x && !rd_q && !tea_i && ta_i && more;
        last_commit   = confirm_o && (CNT_W'(pidx_q) == last_cnt - CNT_W'(1));
        abort_o       = tea_i && (state_q != ST_IDLE);
        busy_o        = state_q != ST_IDLE;
    end

    // Tenure state, beat counter and speculative-beat bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= 1'b0;
            burst_q <= 1'b0;
            cnt_q   <= '0;
            pv_q    <= 1'b0;
            pidx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_XFER;
                        rd_q    <= start_rd_i;
                        burst_q <= start_burst_i;
                        cnt_q   <= '0;
                        pv_q    <= 1'b0;
                    end
                end
                ST_XFER: begin
                    if (tea_i) begin
                        pv_q    <= 1'b0;
                        state_q <= retry_i ? ST_FIN : ST_IDLE;
                    end else if (rd_q) begin
                        if (retry_i) begin
                            if (pv_q) begin
                                pv_q  <= 1'b0;
                                cnt_q <= CNT_W'(pidx_q);
                            end
                        end else begin
                            if (take_o) begin
                                pv_q   <= 1'b1;
                                pidx_q <= cnt_q[IDX_W-1:0];
                                cnt_q  <= cnt_q + CNT_W'(1);
                            end else begin
                                pv_q <= 1'b0;
                            end
                            if (last_commit) state_q <= ST_IDLE;
                        end
                    end else if (wr_beat) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q + CNT_W'(1) == last_cnt) state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    if (!retry_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bq_hold.sv
// Data holding and core-side outputs.
// What it does: stores the speculative beat's data and registers the
// commit and error pulses that go to the core.
// Assumes: take and confirm come from bq_ctrl, already qualified.
module bq_hold #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              confirm_i,
    input  logic [IDX_W-1:0]  confirm_idx_i,
    input  logic              abort_i,
    output logic              commit_o,
    output logic [IDX_W-1:0]  commit_idx_o,
    output logic [DATA_W-1:0] commit_data_o,
    output logic              err_o
);
    logic [DATA_W-1:0] pdata_q;

    // Capture the speculative beat's data on its acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)      pdata_q <= '0;
        else if (take_i) pdata_q <= data_i;
    end

    // Register the core-side commit and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_o      <= 1'b0;
            commit_idx_o  <= '0;
            commit_data_o <= '0;
            err_o         <= 1'b0;
        end else begin
            commit_o <= confirm_i;
            err_o    <= abort_i;
            if (confirm_i) begin
                commit_idx_o  <= confirm_idx_i;
                commit_data_o <= pdata_q;
            end
        end
    end
endmodule

// File: rtl/bq_mon.sv
// Retry protocol monitor.
// What it does: flags a retry whose first cycle had no acknowledge in the
// cycle before it.
// Assumes: both inputs are sampled raw, whatever the tenure state.
module bq_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic ta_i,
    input  logic retry_i,
    output logic proto_err_o
);
    logic ta_q;
    logic rt_q;

    // Remember last cycle's handshakes and flag retries that come too early
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_q        <= 1'b0;
            rt_q        <= 1'b0;
            proto_err_o <= 1'b0;
        end else begin
            ta_q        <= ta_i;
            rt_q        <= retry_i;
            proto_err_o <= retry_i && !rt_q && !ta_q;
        end
    end
endmodule

// File: rtl/beat_qualifier.sv
// Speculative read beat qualifier, top level.
// What it does: counts beats, commits each read beat one cycle after its
// acknowledge unless it is retried, holds bus busy through retry, and
// reports bus errors and retry protocol violations.
// Assumes: a new tenure starts only from the idle state.
module beat_qualifier #(
    parameter int DATA_W    = 64,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_rd_i,
    input  logic              start_burst_i,
    input  logic              ta_i,
    input  logic              retry_i,
    input  logic              tea_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              commit_o,
    output logic [((BURST_LEN > 1) ? $clog2(BURST_LEN) : 1)-1:0] commit_idx_o,
    output logic [DATA_W-1:0] commit_data_o,
    output logic              err_o,
    output logic              proto_err_o
);
    localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    logic             take;
    logic             confirm;
    logic [IDX_W-1:0] confirm_idx;
    logic             abort;

    bq_ctrl #(.BURST_LEN(BURST_LEN), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .start_rd_i(start_rd_i), .start_burst_i(start_burst_i),
        .ta_i(ta_i), .retry_i(retry_i), .tea_i(tea_i),
        .busy_o(busy_o), .take_o(take), .confirm_o(confirm),
        .confirm_idx_o(confirm_idx), .abort_o(abort)
    );

    bq_hold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .take_i(take), .data_i(data_i),
        .confirm_i(confirm), .confirm_idx_i(confirm_idx), .abort_i(abort),
        .commit_o(commit_o), .commit_idx_o(commit_idx_o),
        .commit_data_o(commit_data_o), .err_o(err_o)
    );

    bq_mon u_mon (
        .clk(clk), .rst_n(rst_n),
        .ta_i(ta_i), .retry_i(retry_i),
        .proto_err_o(proto_err_o)
    );
endmodule

// File: rtl/bq_checker.sv
// Temporal properties of the beat qualifier, bound to the top level.
module bq_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic retry_i,
    input logic tea_i,
    input logic busy_o,
    input logic commit_o,
    input logic err_o,
    input logic proto_err_o
);
    // R1: outputs quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !busy_o && !commit_o && !err_o && !proto_err_o);

    // R2: busy only rises after a start pulse
    a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

    // R3: commits happen only inside a tenure
    a_r3_commit_in_tenure: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(busy_o));

    // R4: nothing commits right after a retry cycle
    a_r4_no_commit_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> !$past(retry_i));

    // R8: retry holds the bus busy
    a_r8_busy_held_in_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && retry_i) |=> busy_o);

    // R9: a protocol flag always follows a retry cycle
    a_r9_proto_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $past(retry_i));

    // R10: an error pulse never comes with a commit
    a_r10_err_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !commit_o);

    // R10: bus error without retry releases the bus at once
    a_r10_release_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tea_i && !retry_i) |=> !busy_o);
endmodule

bind beat_qualifier bq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .retry_i(retry_i),
    .tea_i(tea_i), .busy_o(busy_o), .commit_o(commit_o),
    .err_o(err_o), .proto_err_o(proto_err_o)
);

// File: tb/beat_qualifier_tb.sv
module beat_qualifier_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 64;
    localparam int IW   = 2;
    localparam int BLEN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 0, start_rd_i = 0, start_burst_i = 0;
    logic          ta_i = 0, retry_i = 0, tea_i = 0;
    logic [DW-1:0] data_i = '0;
    logic          busy_o, commit_o, err_o, proto_err_o;
    logic [IW-1:0] commit_idx_o;
    logic [DW-1:0] commit_data_o;

    int n_chk = 0, n_bad = 0, n_commits = 0;
    string btag = "R8";
    string ctag = "R3";

    // reference state built from the requirements
    int m_st = 0, m_cnt = 0, m_pidx = 0;
    bit m_rd = 0, m_b = 0, m_pv = 0, m_taq = 0, m_rtq = 0, m_err_seen = 0;
    logic [DW-1:0] m_pdata = '0;
    bit e_busy, e_commit, e_err, e_proto;
    int e_idx;
    logic [DW-1:0] e_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    beat_qualifier #(.DATA_W(DW), .BURST_LEN(BLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_rd_i(start_rd_i),
        .start_burst_i(start_burst_i), .ta_i(ta_i), .retry_i(retry_i),
        .tea_i(tea_i), .data_i(data_i), .busy_o(busy_o), .commit_o(commit_o),
        .commit_idx_o(commit_idx_o), .commit_data_o(commit_data_o),
        .err_o(err_o), .proto_err_o(proto_err_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int nbeats(input bit burst);
        return burst ? BLEN : 1;
    endfunction

    // advance the reference by one cycle of inputs
    task automatic model(input bit st, input bit srd, input bit sb, input bit ta,
                         input bit rt, input bit tea, input logic [DW-1:0] d);
        bit last;
        e_commit = 0;
        e_err    = tea && (m_st != 0);
        e_proto  = rt && !m_rtq && !m_taq;
        case (m_st)
            0: if (st) begin m_st = 1; m_rd = srd; m_b = sb; m_cnt = 0; m_pv = 0; end
            1: begin
                if (tea) begin
                    m_pv = 0; m_st = rt ? 2 : 0; m_err_seen = 1;
                end else if (m_rd) begin
                    if (rt) begin
                        if (m_pv) begin m_pv = 0; m_cnt = m_pidx; end
                    end else begin
                        last = 0;
                        if (m_pv) begin
                            e_commit = 1; e_idx = m_pidx; e_data = m_pdata;
                            last = (m_pidx == nbeats(m_b) - 1);
                        end
                        if (ta && m_cnt < nbeats(m_b)) begin
                            m_pv = 1; m_pidx = m_cnt; m_pdata = d; m_cnt++;
                        end else m_pv = 0;
                        if (last) m_st = 0;
                    end
                end else if (ta && m_cnt < nbeats(m_b)) begin
                    m_cnt++;
                    if (m_cnt == nbeats(m_b)) m_st = 2;
                end
            end
            default: if (!rt) m_st = 0;
        endcase
        e_busy = m_st != 0;
        m_taq = ta; m_rtq = rt;
    endtask

    // drive one cycle, update the reference, compare at the falling edge
    task automatic step(input bit st, input bit srd, input bit sb,
                        input bit ta, input bit rt, input bit tea);
        logic [DW-1:0] d;
        d = {$urandom, $urandom};
        start_i = st; start_rd_i = srd; start_burst_i = sb;
        ta_i = ta; retry_i = rt; tea_i = tea; data_i = d;
        @(posedge clk);
        model(st, srd, sb, ta, rt, tea, d);
        @(negedge clk);
        check(btag, "busy_o", DW'(busy_o), DW'(e_busy));
        check(ctag, "commit_o", DW'(commit_o), DW'(e_commit));
        if (e_commit && commit_o) begin
            check("R4", "commit_idx_o", DW'(commit_idx_o), DW'(e_idx));
            check("R3", "commit_data_o", commit_data_o, e_data);
        end
        check("R10", "err_o", DW'(err_o), DW'(e_err));
        check("R9", "proto_err_o", DW'(proto_err_o), DW'(e_proto));
        if (commit_o) n_commits++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "busy_o", DW'(busy_o), 0);
        check("R1", "commit_o", DW'(commit_o), 0);
        check("R1", "err_o", DW'(err_o), 0);
        check("R1", "proto_err_o", DW'(proto_err_o), 0);

        // R2: start opens tenure; a start while busy is ignored
        btag = "R2";
        step(1, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R2", "busy after single read, late start ignored", DW'(busy_o), 0);

        // R3/R6: back-to-back read burst
        btag = "R6"; n_commits = 0;
        step(1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R6", "burst busy release", DW'(busy_o), 0);
        step(0, 0, 0, 0, 0, 0);
        check("R6", "burst commit count", DW'(n_commits), 4);

        // R5: acknowledge gaps stall the burst
        ctag = "R5"; n_commits = 0;
        step(1, 1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R5", "no commit while stalled", DW'(commit_o), 0);
        for (int i = 0; i < 3; i++) begin step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 0, 0); end
        idle(2);
        check("R5", "stalled burst commit count", DW'(n_commits), 4);

        // R4: retry on beat 1 with acknowledge held through retry
        ctag = "R4"; n_commits = 0;
        step(1, 1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 1, 1, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0);
        idle(3);
        check("R4", "retried burst commit count", DW'(n_commits), 4);

        // R7: write burst, retry mid-burst and after the last beat
        btag = "R7"; ctag = "R7";
        step(1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, 0);
        check("R7", "busy held by retry after write", DW'(busy_o), 1);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R8", "busy after retry ends", DW'(busy_o), 0);

        // R9: retry with no acknowledge before it
        btag = "R8"; ctag = "R3";
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0);

        // R10: bus error with a speculative beat pending, then with retry
        btag = "R10"; n_commits = 0;
        step(1, 1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 0, 0);
        check("R10", "commits after error", DW'(n_commits), 0);
        step(1, 1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        btag = "R8";

        // random tenures
        for (int k = 0; k < 400; k++) begin
            bit rd, bu;
            int guard;
            rd = $urandom % 2; bu = $urandom % 3 != 0;
            n_commits = 0; m_err_seen = 0;
            step(1, rd, bu, 0, 0, 0);
            guard = 0;
            while (m_st != 0 && guard < 200) begin
                bit ta, rt, te;
                ta = ($urandom % 10) < 7;
                rt = (m_taq || m_rtq) ? ($urandom % 4 == 0) : ($urandom % 50 == 0);
                te = $urandom % 60 == 0;
                step(0, 0, 0, ta, rt, te);
                guard++;
            end
            while (m_st != 0) step(0, 0, 0, 0, 0, 1);
            step(0, 0, 0, 0, 0, 0);
            if (!m_err_seen)
                check("R6", "tenure commit count", DW'(n_commits), rd ? DW'(nbeats(bu)) : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule